// File: doc/BRIEF.md
# Two-Rail Phase-Tagged Storage Cell Chain

This block stores single bits carried on two wires that hold both a logic value and a phase tag. Each storage cell compares three phases: the phase arriving at its input, the phase it holds, and the phase reported back by the cell after it. It captures a new bit only when the input carries a fresh phase and the next cell has already taken the bit currently held. Because the handshake uses two phases, a change in the level of the acknowledge is what tells a cell that its bit was consumed.

Cells are chained into an elastic pipeline. Each cell's held bit feeds the next cell. Each cell's phase output feeds the acknowledge of the cell before it. The phase output of the first cell goes back to the producer, and the consumer drives the acknowledge of the last cell.

Back-pressure works as follows. A producer may present a new bit only after `head_done` shows the phase of the bit it sent last. A consumer releases the bit at the tail by driving `tail_ack` to the level of `tail_done`.

The cell is modelled as a clocked register whose enable is the capture condition. A synchronous reset clears every cell. A synchronous set loads a chosen phase and value into each cell.

Rail order is `{r1, r0}`. The value bit is bit 1 of each two-bit rail field, and the phase is the XOR of the two rails.

Top module: `drl_chain`

## Requirements
- R1: In phase 0 a cell holding logic 0 shows rails `2'b00`, and one holding logic 1 shows `2'b11`.
- R2: In phase 1 a cell holding logic 0 shows rails `2'b01`, and one holding logic 1 shows `2'b10`.
- R3: Outside set and reset, the rails of a cell change by at most one wire per clock, whatever the value moved.
- R4: A cell loads its input rails on a clock edge when the input phase differs from its held phase and its held phase equals its acknowledge input.
- R5: A cell whose held phase differs from its acknowledge input keeps its rails unchanged (back-pressure). A full chain therefore leaves `head_done` at the phase of the last accepted bit.
- R6: A cell whose input phase equals its held phase keeps its rails unchanged.
- R7: Each cell's done output equals the phase of the rails it holds; `head_done` and `tail_done` are those of the first and last cells.
- R8: Across the chain, a bit presented at the head with `tail_ack` equal to `tail_done` reaches the tail on the STAGES-th clock edge. The chain holds up to STAGES bits of alternating phase.
- R9: Reset, which is synchronous and active high, clears every cell to phase 0 and value 0 (rails `2'b00`) on the next edge, and takes priority over set.
- R10: With `set_en` high and no reset, cell k loads phase `set_phase[k]` and value `set_value[k]` on the next edge, overriding any capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the cell registers |
| rst | input | 1 | Synchronous active-high clear |
| set_en | input | 1 | Synchronous load of chosen phases and values |
| set_phase | input | STAGES | Phase to load, bit k for cell k |
| set_value | input | STAGES | Value to load, bit k for cell k |
| head_rail | input | 2 | Two-rail bit from the producer |
| head_done | output | 1 | Phase held by the first cell (acknowledge to the producer) |
| tail_ack | input | 1 | Acknowledge phase from the consumer to the last cell |
| tail_rail | output | 2 | Two-rail bit held by the last cell |
| tail_done | output | 1 | Phase held by the last cell |
| stage_rail | output | 2*STAGES | Rails of all cells, cell k in bits 2k+1:2k |

## Verification
The bench builds the chain with STAGES = 4. This depth is enough for a bit to take four edges from head to tail, and for the chain to fill with four alternating-phase bits so that a fifth one is refused at the head. A set pattern that mixes phase 0 and phase 1 with both values shows all four rail codes at once. A scoreboard stream with a consumer that stalls for a varying number of cycles shows bits arriving in order, each one moving a single wire at the tail.

// File: rtl/drl_pkg.sv
package drl_pkg;
  typedef logic [1:0] rail_t;

  // rails {r1, r0}: value on r1, phase = r1 ^ r0
  function automatic rail_t rail_pack(input logic value, input logic phase);
    return {value, value ^ phase};
  endfunction
endpackage

// File: rtl/drl_decode.sv
module drl_decode
  import drl_pkg::*;
(
  input  rail_t rail,
  output logic  phase,
  output logic  value
);
  assign phase = rail[1] ^ rail[0];
  assign value = rail[0] ^ phase;
endmodule

// File: rtl/drl_cell.sv
module drl_cell
  import drl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  set_en,
  input  logic  set_phase,
  input  logic  set_value,
  input  rail_t d_in,
  input  logic  ack_in,
  output rail_t d_out,
  output logic  done
);
  rail_t held;
  logic  in_phase, in_value;
  logic  held_phase, held_value;
  logic  capture;

  drl_decode u_in_dec   (.rail(d_in), .phase(in_phase),   .value(in_value));
  drl_decode u_held_dec (.rail(held), .phase(held_phase), .value(held_value));

  assign capture = (in_phase != held_phase) && (held_phase == ack_in);

  always_ff @(posedge clk) begin
    if (rst)          held <= rail_pack(1'b0, 1'b0);
    else if (set_en)  held <= rail_pack(set_value, set_phase);
    else if (capture) held <= d_in;
  end

  assign d_out = held;
  assign done  = held_phase;

  // R4: fresh input with consumed output is taken on the next edge
  a_r4_capture: assert property (@(posedge clk) disable iff (rst)
    (!set_en && in_phase != done && done == ack_in) |=>
      (done == $past(in_phase) && held_value == $past(in_value)));

  // R5: unconsumed bit is held
  a_r5_hold_ack: assert property (@(posedge clk) disable iff (rst)
    (!set_en && done != ack_in) |=> $stable(d_out));

  // R6: no fresh phase, no change
  a_r6_hold_same: assert property (@(posedge clk) disable iff (rst)
    (!set_en && in_phase == done) |=> $stable(d_out));

  // R3: at most one wire moves per edge
  a_r3_one_wire: assert property (@(posedge clk) disable iff (rst)
    (!set_en) |=> ($countones(d_out ^ $past(d_out)) <= 1));

  // R10: set loads chosen phase and value
  a_r10_set_load: assert property (@(posedge clk) disable iff (rst)
    set_en |=> (done == $past(set_phase) && held_value == $past(set_value)));
endmodule

// File: rtl/drl_chain.sv
module drl_chain
  import drl_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  set_en,
  input  logic [STAGES-1:0]     set_phase,
  input  logic [STAGES-1:0]     set_value,
  input  logic [1:0]            head_rail,
  output logic                  head_done,
  input  logic                  tail_ack,
  output logic [1:0]            tail_rail,
  output logic                  tail_done,
  output logic [2*STAGES-1:0]   stage_rail
);
  localparam int LAST = STAGES - 1;

  rail_t             link [STAGES];
  logic [STAGES-1:0] dn;

  for (genvar k = 0; k < STAGES; k++) begin : g_cell
    rail_t cell_in;
    logic  cell_ack;
    if (k == 0) begin : g_head
      assign cell_in = head_rail;
    end else begin : g_mid_in
      assign cell_in = link[k-1];
    end
    if (k == LAST) begin : g_tail
      assign cell_ack = tail_ack;
    end else begin : g_mid_ack
      assign cell_ack = dn[k+1];
    end

    drl_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .set_en    (set_en),
      .set_phase (set_phase[k]),
      .set_value (set_value[k]),
      .d_in      (cell_in),
      .ack_in    (cell_ack),
      .d_out     (link[k]),
      .done      (dn[k])
    );
    assign stage_rail[2*k +: 2] = link[k];
  end

  assign head_done = dn[0];
  assign tail_done = dn[LAST];
  assign tail_rail = link[LAST];

  // R9: reset clears every cell
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (stage_rail == '0));

  // R7: tail phase output agrees with tail rails
  a_r7_tail_phase: assert property (@(posedge clk) disable iff (rst)
    tail_done == (tail_rail[1] ^ tail_rail[0]));
endmodule

// File: tb/drl_chain_test.sv
module drl_chain_test;
  localparam int STAGES = 4;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                set_en = 1'b0;
  logic [STAGES-1:0]   set_phase = '0;
  logic [STAGES-1:0]   set_value = '0;
  logic [1:0]          head_rail = 2'b00;
  logic                head_done;
  logic                tail_ack = 1'b0;
  logic [1:0]          tail_rail;
  logic                tail_done;
  logic [2*STAGES-1:0] stage_rail;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  bit   exp_q[$];
  bit   mon_on = 0;
  int   wait_cnt = 0;
  int   pops = 0;
  logic [1:0] prev_tail = 2'b00;
  logic hp = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  drl_chain #(.STAGES(STAGES)) uut (
    .clk(clk), .rst(rst), .set_en(set_en), .set_phase(set_phase),
    .set_value(set_value), .head_rail(head_rail), .head_done(head_done),
    .tail_ack(tail_ack), .tail_rail(tail_rail), .tail_done(tail_done),
    .stage_rail(stage_rail)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1; head_rail = 2'b00; tail_ack = 1'b0; hp = 1'b0;
    cycles(2);
    rst = 1'b0;
  endtask

  // driver: sends one bit with a fresh phase, then waits for the head to take it
  task automatic send(input bit v);
    hp = ~hp;
    head_rail = {v, v ^ hp};
    exp_q.push_back(v);
    @(negedge clk);
    while (head_done != hp) @(negedge clk);
  endtask

  // monitor / consumer with a varying stall
  always @(negedge clk) begin
    if (mon_on && !rst && tail_done != tail_ack) begin
      if (wait_cnt >= (pops % 3)) begin
        bit e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b0;
        chk(tail_rail[1] == e, "R8 stream order", tail_rail[1], e);
        chk(tail_done == (tail_rail[1] ^ tail_rail[0]), "R7 tail phase",
            tail_done, tail_rail[1] ^ tail_rail[0]);
        chk($countones(tail_rail ^ prev_tail) == 1, "R3 single wire",
            tail_rail ^ prev_tail, 1);
        prev_tail = tail_rail;
        tail_ack = tail_done;
        pops++;
        wait_cnt = 0;
      end else begin
        wait_cnt++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk(stage_rail == '0, "R9 reset rails", stage_rail, 0);
    chk(head_done == 1'b0, "R9 reset head phase", head_done, 0);
    chk(tail_done == 1'b0, "R9 reset tail phase", tail_done, 0);

    // R6: input phase equals held phase, nothing moves
    cycles(5);
    chk(stage_rail == '0, "R6 no fresh phase", stage_rail, 0);

    // R10 with R1/R2 codes: s0 p1 v1, s1 p0 v1, s2 p1 v0, s3 p0 v0
    set_phase = 4'b0101; set_value = 4'b0011; set_en = 1'b1;
    @(negedge clk);
    set_en = 1'b0;
    chk(stage_rail[1:0] == 2'b10, "R2 phase1 one", stage_rail[1:0], 2'b10);
    chk(stage_rail[3:2] == 2'b11, "R1 phase0 one", stage_rail[3:2], 2'b11);
    chk(stage_rail[5:4] == 2'b01, "R2 phase1 zero", stage_rail[5:4], 2'b01);
    chk(stage_rail[7:6] == 2'b00, "R1 phase0 zero", stage_rail[7:6], 2'b00);
    chk(head_done == 1'b1, "R10 set head phase", head_done, 1);

    // R9 priority over set
    rst = 1'b1; set_en = 1'b1;
    @(negedge clk);
    rst = 1'b0; set_en = 1'b0;
    chk(stage_rail == '0, "R9 reset beats set", stage_rail, 0);

    // R8 latency and fill with tail_ack held at 0
    do_reset();
    head_rail = 2'b10; // A: phase1 value1
    cycles(3);
    chk(tail_done == 1'b0, "R8 not yet at tail", tail_done, 0);
    @(negedge clk);
    chk(tail_rail == 2'b10, "R8 reaches tail on 4th edge", tail_rail, 2'b10);
    head_rail = 2'b00; cycles(8);   // B phase0 value0
    head_rail = 2'b01; cycles(8);   // C phase1 value0
    head_rail = 2'b11; cycles(8);   // D phase0 value1
    chk(stage_rail == 8'b10000111, "R8 chain full", stage_rail, 8'h87);
    chk(tail_rail == 2'b10, "R5 tail held", tail_rail, 2'b10);
    head_rail = 2'b10; cycles(4);   // E phase1 value1 refused
    chk(head_done == 1'b0, "R5 head refuses", head_done, 0);
    chk(stage_rail[1:0] == 2'b11, "R5 first cell held", stage_rail[1:0], 2'b11);
    tail_ack = 1'b1;
    @(negedge clk);
    chk(tail_rail == 2'b00, "R4 tail takes next bit", tail_rail, 2'b00);

    // scoreboard stream with stalling consumer
    do_reset();
    prev_tail = 2'b00; pops = 0; wait_cnt = 0;
    mon_on = 1;
    for (int i = 0; i < 24; i++) send(((i * 5) ^ (i >> 2)) & 1);
    for (int i = 0; i < 200 && exp_q.size() > 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R8 stream drained", exp_q.size(), 0);
    chk(pops == 24, "R8 stream count", pops, 24);
    mon_on = 0;

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule